// File: doc/BRIEF.md
# CPU Exception Priority Arbiter

This block sits next to a CPU core's instruction sequencer and picks which exception, if any, begins at each instruction boundary. A boundary is signalled by a one-cycle strobe whenever an instruction or an exception-handling sequence completes. The strobe carries a class code, so the arbiter can apply context-dependent suppression. After a return-from-exception no trace is taken. After an instruction that modifies the condition register, and at the first boundary after a reset start, no interrupt is accepted.

Reset is special. A rising edge on the (synchronised) active-low reset pin, or a watchdog overflow pulse, starts the reset exception on the next cycle without waiting for a boundary. While the pin is low the core is held in reset. Direct-transition and trap requests are single-cycle pulses that the arbiter latches until they are served. The interrupt request is a level owned by the interrupt controller. Trace is evaluated afresh at every boundary. Every start is a one-cycle one-hot strobe together with a 3-bit type code.

Top module: `exc_prio_arb`

## Requirements
- R1: At most one exception starts per cycle. When several are eligible at one boundary, the order is trace, direct transition, interrupt, trap. Reset outranks all of them. Type codes on `exc_type_o`: 0 none, 1 reset, 2 trace, 3 direct transition, 4 interrupt, 5 trap. `exc_start_o` bit k is set exactly when the type is k+1.
- R2: `res_n_i` passes through a two-flop synchroniser. `hold_rst_o` is high while the synchronised pin is low, and no exception starts during that time. The synchronised low-to-high edge starts reset. The start appears three clock edges after the pin rises.
- R3: A `wdt_ovf_i` pulse outside the hold state starts reset on the next cycle, whether or not a boundary is present. Any boundary in that cycle is discarded.
- R4: At a boundary, trace starts when `trace_en_i` is 1 and `ctl_mode_i` equals 2.
- R5: With `ctl_mode_i` other than 2, `trace_en_i` has no effect.
- R6: No trace starts at a boundary whose class `cls_i` is 1 (return-from-exception).
- R7: A `dtrans_req_i` pulse is latched and starts the direct-transition exception at the next boundary where nothing of higher rank is eligible.
- R8: `irq_pend_i` is accepted at a boundary unless `cls_i` is 2 (condition-register AND/OR/XOR/load). Class 0 is an ordinary instruction and class 3 is the end of exception handling.
- R9: The first boundary after a reset start never accepts an interrupt.
- R10: A `trap_req_i` pulse is latched. It stays pending across boundaries served by higher-rank exceptions until it is itself started, independent of `irq_pend_i`.
- R11: A reset start, or the hold state, discards pending direct-transition and trap requests. Requests arriving during hold are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Block asynchronous reset, active low |
| res_n_i | input | 1 | CPU reset pin, active low, asynchronous |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| trace_en_i | input | 1 | Trace enable bit |
| ctl_mode_i | input | 2 | Interrupt control mode field |
| dtrans_req_i | input | 1 | Direct-transition request pulse from sleep |
| irq_pend_i | input | 1 | Interrupt pending level |
| trap_req_i | input | 1 | Trap instruction request pulse |
| boundary_i | input | 1 | Instruction/exception-handling completion strobe |
| cls_i | input | 2 | Class of the completing item (0 normal, 1 RTE, 2 CCR op, 3 exception end) |
| exc_start_o | output | 5 | One-hot exception start strobe |
| exc_type_o | output | 3 | Encoded exception type |
| hold_rst_o | output | 1 | Core held in reset |

## Verification
The hardest situations to reach combine a latched request with suppression. One case is a trap pulse that must outlive several interrupt-served boundaries. Another is a direct-transition request that a watchdog reset must silently discard. A third is the single boundary right after reset, where a pending interrupt has to be refused. The stimulus reaches these with directed sequences. Pulses are placed a few cycles ahead of chosen boundaries, and the reset pin is dropped and raised with the exact synchroniser latency. A long random phase then mixes pin toggles, watchdog pulses and all boundary classes against a behavioural model.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int unsigned N_EXC   = 5;
  localparam int unsigned N_LATCH = 2;

  typedef enum logic [2:0] {
    EXC_NONE   = 3'd0,
    EXC_RESET  = 3'd1,
    EXC_TRACE  = 3'd2,
    EXC_DTRANS = 3'd3,
    EXC_IRQ    = 3'd4,
    EXC_TRAP   = 3'd5
  } exc_e;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_RTE    = 2'd1,
    CLS_CCR    = 2'd2,
    CLS_EXC    = 2'd3
  } cls_e;

  function automatic exc_e onehot_to_type(input logic [N_EXC-1:0] oh);
    exc_e t;
    t = EXC_NONE;
    for (int i = N_EXC - 1; i >= 0; i--)
      if (oh[i]) t = exc_e'(i + 1);
    return t;
  endfunction
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  input  logic wdt_i,
  output logic hold_o,
  output logic req_o
);
  logic [STAGES-1:0] sync_q;
  logic              res_s;
  logic              res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      res_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_n_i};
      res_q  <= res_s;
    end
  end

  assign res_s  = sync_q[STAGES-1];
  assign hold_o = ~res_s;
  // rising edge of released pin, or watchdog outside hold
  assign req_o  = res_s & (~res_q | wdt_i);

  p_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> req_o);
endmodule

// File: rtl/exc_pend_bank.sv
module exc_pend_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q[i] <= 1'b0;
      else if (flush_i)   pend_q[i] <= 1'b0;
      else if (clr_i[i])  pend_q[i] <= 1'b0;
      else                pend_q[i] <= pend_q[i] | set_i[i];
    end

    p_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_q[i] && !clr_i[i] && !flush_i |=> pend_q[i]);
  end

  // a pulse arriving in the boundary cycle is already eligible
  assign pend_o = pend_q | set_i;
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int unsigned N = 4
) (
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]   = en_i & req_i[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req_i[i];
  end
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_arb_pkg::*;
#(
  parameter logic [1:0]  TRACE_MODE  = 2'd2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_n_i,
  input  logic             wdt_ovf_i,
  input  logic             trace_en_i,
  input  logic [1:0]       ctl_mode_i,
  input  logic             dtrans_req_i,
  input  logic             irq_pend_i,
  input  logic             trap_req_i,
  input  logic             boundary_i,
  input  logic [1:0]       cls_i,
  output logic [N_EXC-1:0] exc_start_o,
  output logic [2:0]       exc_type_o,
  output logic             hold_rst_o
);
  localparam int unsigned N_BND = N_EXC - 1;

  logic               hold, rst_req, run, bnd_ok;
  logic [N_LATCH-1:0] pend, clr;
  logic [N_BND-1:0]   bnd_req, bnd_gnt;
  logic               trace_ok, irq_ok;
  logic               aft_rst_q;
  logic [N_EXC-1:0]   start_d, start_q;
  exc_e               type_q;

  exc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_n_i (res_n_i),
    .wdt_i   (wdt_ovf_i),
    .hold_o  (hold),
    .req_o   (rst_req)
  );

  assign run    = ~hold & ~rst_req;
  assign bnd_ok = run & boundary_i;

  // latched sources: bit0 direct transition, bit1 trap
  exc_pend_bank #(.N(N_LATCH)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({trap_req_i, dtrans_req_i}),
    .clr_i   (clr),
    .flush_i (~run),
    .pend_o  (pend)
  );

  assign trace_ok = trace_en_i & (ctl_mode_i == TRACE_MODE) & (cls_e'(cls_i) != CLS_RTE);
  assign irq_ok   = irq_pend_i & (cls_e'(cls_i) != CLS_CCR) & ~aft_rst_q;

  // rank order: trace, direct transition, interrupt, trap
  assign bnd_req = {pend[1], irq_ok, pend[0], trace_ok};

  exc_prio_sel #(.N(N_BND)) u_sel (
    .en_i  (bnd_ok),
    .req_i (bnd_req),
    .gnt_o (bnd_gnt)
  );

  assign clr     = {bnd_gnt[3], bnd_gnt[1]};
  assign start_d = rst_req ? N_EXC'(1) : {bnd_gnt, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= '0;
      type_q    <= EXC_NONE;
      aft_rst_q <= 1'b1;
    end else begin
      start_q <= start_d;
      type_q  <= onehot_to_type(start_d);
      if (rst_req)     aft_rst_q <= 1'b1;
      else if (bnd_ok) aft_rst_q <= 1'b0;
    end
  end

  assign exc_start_o = start_q;
  assign exc_type_o  = type_q;
  assign hold_rst_o  = hold;

  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(exc_start_o));

  p_hold_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst_o && $past(hold_rst_o) |-> exc_start_o == '0);

  p_wdt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_ovf_i && !hold_rst_o |=> exc_type_o == EXC_RESET);

  p_trace_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_type_o == EXC_TRACE |-> $past(ctl_mode_i) == TRACE_MODE);

  p_trace_rte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_type_o == EXC_TRACE |-> $past(cls_i) != CLS_RTE);

  p_at_bnd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_type_o != EXC_NONE && exc_type_o != EXC_RESET) |-> $past(boundary_i));

  p_irq_ccr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_type_o == EXC_IRQ |-> $past(cls_i) != CLS_CCR);
endmodule

// File: tb/exc_prio_arb_tb_top.sv
module exc_prio_arb_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       res_n_i = 1'b0;
  logic       wdt_ovf_i = 1'b0;
  logic       trace_en_i = 1'b0;
  logic [1:0] ctl_mode_i = 2'd0;
  logic       dtrans_req_i = 1'b0;
  logic       irq_pend_i = 1'b0;
  logic       trap_req_i = 1'b0;
  logic       boundary_i = 1'b0;
  logic [1:0] cls_i = 2'd0;
  logic [4:0] exc_start_o;
  logic [2:0] exc_type_o;
  logic       hold_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  always #2 clk_i = ~clk_i;

  exc_prio_arb dut_i (.*);

  // behavioural reference model
  bit m1, m2, m3, mdt, mtr, maft, rs, rq, hold, rreq, dt, tp;
  int et = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m1 = 0; m2 = 0; m3 = 0; mdt = 0; mtr = 0; maft = 1; et = 0;
    end else begin
      rs = m2; rq = m3; hold = !rs;
      rreq = rs && (!rq || wdt_ovf_i);
      et = 0;
      if (rreq) begin
        et = 1; mdt = 0; mtr = 0; maft = 1;
      end else if (hold) begin
        mdt = 0; mtr = 0;
      end else begin
        dt = mdt | dtrans_req_i;
        tp = mtr | trap_req_i;
        if (boundary_i) begin
          if (trace_en_i && ctl_mode_i == 2'd2 && cls_i != 2'd1) et = 2;
          else if (dt) begin et = 3; dt = 0; end
          else if (irq_pend_i && cls_i != 2'd2 && !maft) et = 4;
          else if (tp) begin et = 5; tp = 0; end
          maft = 0;
        end
        mdt = dt; mtr = tp;
      end
      m3 = m2; m2 = m1; m1 = res_n_i;
    end
  end

  function automatic string tag_of(input int t);
    case (t)
      1: return "R2/R3";
      2: return "R4/R5/R6";
      3: return "R7";
      4: return "R8/R9";
      5: return "R10/R11";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (cmp_en) begin
      logic [4:0] es;
      es = (et == 0) ? 5'd0 : 5'(1 << (et - 1));
      n_chk++;
      if (exc_type_o != 3'(et) || exc_start_o != es) begin
        n_fail++;
        $display("FAIL %s model: type=%0d start=%b expected type=%0d start=%b",
                 tag_of(et), exc_type_o, exc_start_o, et, es);
      end
      n_chk++;
      if (hold_rst_o != !m2) begin
        n_fail++;
        $display("FAIL R2 model hold: got %0b expected %0b", hold_rst_o, !m2);
      end
    end
  end

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic bnd(input logic [1:0] c, input logic [2:0] exp, input string tag);
    boundary_i = 1'b1; cls_i = c;
    @(negedge clk_i);
    boundary_i = 1'b0; cls_i = 2'd0;
    chk(tag, exc_type_o, exp);
  endtask

  task automatic pulse_dt();
    dtrans_req_i = 1'b1; @(negedge clk_i); dtrans_req_i = 1'b0;
  endtask

  task automatic pulse_tp();
    trap_req_i = 1'b1; @(negedge clk_i); trap_req_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk_i);
    chk("R2 reset-state hold", 3'(hold_rst_o), 3'd1);
    chk("R1 reset-state type", exc_type_o, 3'd0);

    // release reset pin: start three edges later
    res_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R2 reset start", exc_type_o, 3'd1);
    chk("R2 hold released", 3'(hold_rst_o), 3'd0);

    irq_pend_i = 1'b1;
    bnd(2'd3, 3'd0, "R9 irq after reset");
    bnd(2'd0, 3'd4, "R8 irq accepted");
    bnd(2'd2, 3'd0, "R8 irq after ccr op");
    bnd(2'd3, 3'd4, "R8 irq at exception end");
    irq_pend_i = 1'b0;

    trace_en_i = 1'b1; ctl_mode_i = 2'd2;
    bnd(2'd0, 3'd2, "R4 trace");
    bnd(2'd1, 3'd0, "R6 no trace after rte");
    ctl_mode_i = 2'd0;
    bnd(2'd0, 3'd0, "R5 trace mode 0");
    ctl_mode_i = 2'd1;
    bnd(2'd0, 3'd0, "R5 trace mode 1");
    ctl_mode_i = 2'd3;
    bnd(2'd0, 3'd0, "R5 trace mode 3");

    // everything pending together
    ctl_mode_i = 2'd2;
    pulse_dt(); pulse_tp();
    irq_pend_i = 1'b1;
    bnd(2'd0, 3'd2, "R1 trace first");
    trace_en_i = 1'b0;
    bnd(2'd0, 3'd3, "R1 R7 dtrans second");
    bnd(2'd0, 3'd4, "R1 irq third");
    irq_pend_i = 1'b0;
    bnd(2'd0, 3'd5, "R10 trap last");
    bnd(2'd0, 3'd0, "R1 nothing left");

    // trap outlives interrupt-served boundaries
    pulse_tp();
    irq_pend_i = 1'b1;
    repeat (3) @(negedge clk_i);
    bnd(2'd0, 3'd4, "R10 irq over trap");
    bnd(2'd0, 3'd4, "R10 irq over trap again");
    irq_pend_i = 1'b0;
    bnd(2'd0, 3'd5, "R10 trap still pending");

    // watchdog discards pending request and boundary
    pulse_dt();
    wdt_ovf_i = 1'b1; boundary_i = 1'b1;
    @(negedge clk_i);
    wdt_ovf_i = 1'b0; boundary_i = 1'b0;
    chk("R3 watchdog reset", exc_type_o, 3'd1);
    bnd(2'd3, 3'd0, "R11 dtrans flushed by reset");

    // hold state ignores requests
    res_n_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R2 hold asserted", 3'(hold_rst_o), 3'd1);
    pulse_tp();
    bnd(2'd0, 3'd0, "R11 no start in hold");
    res_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R2 reset after hold", exc_type_o, 3'd1);
    bnd(2'd3, 3'd0, "R11 trap dropped in hold");

    // random mix checked by the model
    for (int i = 0; i < 4000; i++) begin
      boundary_i   = ($urandom % 3) == 0;
      cls_i        = 2'($urandom % 4);
      trace_en_i   = ($urandom % 4) == 0;
      ctl_mode_i   = 2'($urandom % 4);
      irq_pend_i   = ($urandom % 2) == 0;
      dtrans_req_i = ($urandom % 16) == 0;
      trap_req_i   = ($urandom % 12) == 0;
      wdt_ovf_i    = ($urandom % 200) == 0;
      if (($urandom % 400) == 0) res_n_i = 1'b0;
      else if (!res_n_i && ($urandom % 8) == 0) res_n_i = 1'b1;
      @(negedge clk_i);
    end
    boundary_i = 0; dtrans_req_i = 0; trap_req_i = 0; wdt_ovf_i = 0;
    @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule